// File: doc/BRIEF.md
# Single-Precision Round-and-Pack Unit

This unit is the last stage of a single-precision floating-point datapath. An arithmetic stage upstream hands it a sign, a signed unbiased exponent and a 27-bit working significand. In that significand bit 26 is the hidden integer bit, bits 25..3 carry the fraction and bits 2..0 are the guard, round and sticky positions. The unit rounds the value under one of four modes and shifts tiny values into the denormal range. It resolves overflow and the optional flush of tiny results, then emits a packed 32-bit IEEE 754 word with inexact, underflow and overflow flags.

Tininess is judged after rounding at the exponent just below the normal range. If rounding there carries out of the significand, the value becomes the smallest normal number and no underflow is raised. With flush enabled, a tiny input gives a result that depends on the rounding mode and the sign: a signed zero or the smallest denormal. An overflow result is infinity or the largest finite magnitude, chosen from the mode and the sign.

The input is a single valid strobe. With the default build the result appears, registered, on the clock edge after the strobe. A build option removes the register, and a second option picks the implementation of the sticky shifter.

Top module: `sp_round_pack`

## Requirements
- R1: With the default registered build, out_valid is high exactly in the cycle after a cycle with in_valid high. Reset drives out_valid, out_result and all three flags to 0.
- R2: An input with bits 2..0 zero and an exponent from -126 to 127 packs as {sign, exponent+127, significand bits 25..3} and raises no flag. For example +1.0 (exp 0, sig 0x4000000) gives 0x3F800000.
- R3: rnd_mode 0 is round to nearest even. When bits 2..0 are nonzero it adds 3 plus bit 3 to the significand, so an exact half rounds toward an even bit 3.
- R4: rnd_mode 1 (toward zero) adds nothing. rnd_mode 2 (toward +infinity) adds 8 only for positive values. rnd_mode 3 (toward -infinity) adds 8 only for negative values. Each applies only when bits 2..0 are nonzero.
- R5: Nonzero bits 2..0 at rounding time raise out_inexact. If bit 26 is clear at that point (a denormalized value), out_underflow is raised as well. An exact result raises neither flag.
- R6: If rounding carries into bit 27, the significand shifts right by one and the exponent increments. For example an all-ones significand at exp 0 under mode 0 gives 2.0 = 0x40000000.
- R7: An exponent below -126 that is not flushed and not in the R8 case shifts the significand right by (-126 - exponent), with shifted-out ones ORed into bit 0, and uses exponent -126. A final significand with bit 26 clear packs with exponent field 0.
- R8: At exponent -127, if rounding the unshifted significand would carry into bit 27, the result is the smallest normal 0x00800000 (with sign) and raises inexact only.
- R9: Shift amounts of 27 or more leave only the sticky bit (value 1).
- R10: With flush_en high and exponent below -126, out_underflow and out_inexact are raised. Modes 0 and 1 give a signed zero. Mode 2 gives 0x00000001 for positive and 0x80000000 for negative. Mode 3 gives 0x00000000 for positive and 0x80000001 for negative.
- R11: A final exponent above 127 raises out_overflow and out_inexact. The result is infinity ({s,0xFF,0}) for mode 0, for mode 2 when positive and for mode 3 when negative. Otherwise it is the largest finite value {s,0xFE,0x7FFFFF}. No result is ever a NaN.
- R12: A denormalized value that rounds up into bit 26 packs with exponent field 1 and raises both inexact and underflow.
- R13: flush_en has no effect when the exponent is -126 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand valid strobe |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 10 | Signed unbiased exponent (two's complement) |
| in_sig | input | 27 | Significand, hidden bit at 26, guard/round/sticky in 2..0 |
| rnd_mode | input | 2 | 0 nearest even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| flush_en | input | 1 | Flush tiny results |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Inexact flag |
| out_underflow | output | 1 | Underflow flag |
| out_overflow | output | 1 | Overflow flag |

## Verification
The bench builds two copies side by side on the same stimulus. The main copy uses the defaults: an output register and the staged shifter. The second copy has no output register and uses the single-expression shifter. Both are compared against one bench model. The combinational copy shows that the rounding, denormalization and special-result logic does not rely on the register stage. Running both shifter variants across exponents from -512 to 511 checks every shift stage, the saturation at 27 and beyond, and the carry case at exponent -127 in both structures.

// File: rtl/sp_rp_pkg.sv
package sp_rp_pkg;
   typedef enum logic [1:0] {
      RM_NEAREST = 2'd0,
      RM_ZERO    = 2'd1,
      RM_UP      = 2'd2,
      RM_DOWN    = 2'd3
   } rnd_mode_e;
endpackage

// File: rtl/sp_rnd_incr.sv
// Adds the rounding increment selected by mode and sign; only when the
// three low positions are nonzero.
module sp_rnd_incr
   import sp_rp_pkg::*;
#(
   parameter int SIG_W = 27
) (
   input  logic             sign,
   input  logic [1:0]       mode,
   input  logic [SIG_W-1:0] sig_i,
   output logic [SIG_W:0]   sig_o
);
   logic [SIG_W:0] addend;
   logic           lost;

   always_comb begin
      lost   = |sig_i[2:0];
      addend = '0;
      if (lost) begin
         case (mode)
            RM_NEAREST: addend = (SIG_W+1)'(3) + (SIG_W+1)'(sig_i[3]);
            RM_ZERO:    addend = '0;
            RM_UP:      addend = sign ? '0 : (SIG_W+1)'(8);
            RM_DOWN:    addend = sign ? (SIG_W+1)'(8) : '0;
            default:    addend = '0;
         endcase
      end
      sig_o = {1'b0, sig_i} + addend;
   end
endmodule

// File: rtl/sp_sticky_rshift.sv
// Right shift with sticky collection into bit 0; saturates for amt >= W.
module sp_sticky_rshift #(
   parameter int W      = 27,
   parameter int AMT_W  = 12,
   parameter bit STAGED = 1'b1
) (
   input  logic [W-1:0]     d,
   input  logic [AMT_W-1:0] amt,
   output logic [W-1:0]     q
);
   localparam int LG = $clog2(W);

   initial begin : chk_params
      assert (AMT_W > LG) else $fatal(1, "shift amount too narrow");
   end

   logic sat;
   assign sat = (amt >= AMT_W'(W));

   logic [W-1:0] shifted;

   if (STAGED) begin : g_staged
      logic [W-1:0] stg [LG+1];
      assign stg[0] = d;
      for (genvar k = 0; k < LG; k++) begin : g_stage
         localparam int SH = 1 << k;
         assign stg[k+1] = amt[k]
            ? ((stg[k] >> SH) | {{(W-1){1'b0}}, |stg[k][SH-1:0]})
            : stg[k];
      end
      assign shifted = stg[LG];
   end else begin : g_flat
      logic [W-1:0] mask;
      assign mask    = ~({W{1'b1}} << amt);
      assign shifted = (d >> amt) | {{(W-1){1'b0}}, |(d & mask)};
   end

   assign q = sat ? {{(W-1){1'b0}}, |d} : shifted;
endmodule

// File: rtl/sp_special_sel.sv
// Mode- and sign-dependent words for flushed and overflowed results.
module sp_special_sel
   import sp_rp_pkg::*;
#(
   parameter int EXPF_W = 8,
   parameter int FRAC_W = 23
) (
   input  logic                     sign,
   input  logic [1:0]               mode,
   output logic [EXPF_W+FRAC_W:0]   flush_word,
   output logic [EXPF_W+FRAC_W:0]   ovf_word
);
   localparam logic [EXPF_W-1:0] EXP_ONES = '1;
   localparam logic [EXPF_W-1:0] EXP_MAXF = EXP_ONES - EXPF_W'(1);
   localparam logic [FRAC_W-1:0] FRAC_ONE = FRAC_W'(1);

   logic to_min;
   logic to_inf;

   always_comb begin
      case (mode)
         RM_UP:   begin to_min = ~sign; to_inf = ~sign; end
         RM_DOWN: begin to_min = sign;  to_inf = sign;  end
         RM_ZERO: begin to_min = 1'b0;  to_inf = 1'b0;  end
         default: begin to_min = 1'b0;  to_inf = 1'b1;  end
      endcase
      flush_word = {sign, {EXPF_W{1'b0}}, to_min ? FRAC_ONE : {FRAC_W{1'b0}}};
      ovf_word   = to_inf ? {sign, EXP_ONES, {FRAC_W{1'b0}}}
                          : {sign, EXP_MAXF, {FRAC_W{1'b1}}};
   end
endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
   import sp_rp_pkg::*;
#(
   parameter int EXPF_W   = 8,
   parameter int FRAC_W   = 23,
   parameter int EXP_IN_W = 10,
   parameter bit PIPE     = 1'b1,
   parameter bit STAGED   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_sign,
   input  logic [EXP_IN_W-1:0]        in_exp,
   input  logic [FRAC_W+3:0]          in_sig,
   input  logic [1:0]                 rnd_mode,
   input  logic                       flush_en,
   output logic                       out_valid,
   output logic [EXPF_W+FRAC_W:0]     out_result,
   output logic                       out_inexact,
   output logic                       out_underflow,
   output logic                       out_overflow
);
   localparam int SIG_W = FRAC_W + 4;
   localparam int RES_W = 1 + EXPF_W + FRAC_W;
   localparam int BIAS  = (1 << (EXPF_W - 1)) - 1;
   localparam int EW    = EXP_IN_W + 2;
   localparam logic signed [EW-1:0] EMIN_S    = EW'(1 - BIAS);
   localparam logic signed [EW-1:0] EMIN_M1_S = EW'(-BIAS);
   localparam logic signed [EW-1:0] EMAX_S    = EW'(BIAS);

   initial begin : chk_params
      assert (FRAC_W >= 4) else $fatal(1, "FRAC_W too small");
      assert (EXPF_W >= 3) else $fatal(1, "EXPF_W too small");
      assert (EXP_IN_W >= EXPF_W + 2) else $fatal(1, "EXP_IN_W too narrow");
   end

   // ---------------- denormalization ----------------
   logic signed [EW-1:0] xe_in;
   logic                 is_tiny;
   logic                 at_edge;
   logic                 flush_hit;
   logic [EW-1:0]        shamt;
   logic [SIG_W:0]       sig_pre;
   logic [SIG_W-1:0]     sig_sh;

   assign xe_in     = {{(EW-EXP_IN_W){in_exp[EXP_IN_W-1]}}, in_exp};
   assign is_tiny   = (xe_in < EMIN_S);
   assign at_edge   = (xe_in == EMIN_M1_S);
   assign flush_hit = is_tiny & flush_en;
   assign shamt     = EW'(EMIN_S - xe_in);

   sp_rnd_incr #(.SIG_W(SIG_W)) u_pre_rnd (
      .sign  (in_sign),
      .mode  (rnd_mode),
      .sig_i (in_sig),
      .sig_o (sig_pre)
   );

   sp_sticky_rshift #(.W(SIG_W), .AMT_W(EW), .STAGED(STAGED)) u_shift (
      .d   (in_sig),
      .amt (shamt),
      .q   (sig_sh)
   );

   logic signed [EW-1:0] xe_a;
   logic [SIG_W-1:0]     sig_a;
   logic                 nx_a;

   always_comb begin
      xe_a  = xe_in;
      sig_a = in_sig;
      nx_a  = 1'b0;
      if (is_tiny) begin
         xe_a = EMIN_S;
         if (at_edge && sig_pre[SIG_W]) begin
            sig_a = {sig_pre[SIG_W:4], 3'b000};
            nx_a  = 1'b1;
         end else begin
            sig_a = sig_sh;
         end
      end
   end

   // ---------------- main rounding ----------------
   logic                 grs_a;
   logic [SIG_W:0]       sig_r;
   logic [SIG_W-1:0]     sig_b;
   logic signed [EW-1:0] xe_b;

   assign grs_a = |sig_a[2:0];

   sp_rnd_incr #(.SIG_W(SIG_W)) u_main_rnd (
      .sign  (in_sign),
      .mode  (rnd_mode),
      .sig_i (sig_a),
      .sig_o (sig_r)
   );

   always_comb begin
      if (grs_a && sig_r[SIG_W]) begin
         sig_b = sig_r[SIG_W:1];
         xe_b  = xe_a + EW'(1);
      end else begin
         sig_b = sig_r[SIG_W-1:0];
         xe_b  = xe_a;
      end
   end

   // ---------------- pack ----------------
   logic [FRAC_W:0]   mant;
   logic              ovf;
   logic [EW-1:0]     exp_sum;
   logic [EXPF_W-1:0] exp_field;
   logic [RES_W-1:0]  flush_word;
   logic [RES_W-1:0]  ovf_word;
   logic [RES_W-1:0]  res_c;
   logic              nx_c;
   logic              uf_c;
   logic              unused_bits;

   assign mant      = sig_b[SIG_W-1:3];
   assign ovf       = ~flush_hit & (xe_b > EMAX_S);
   assign exp_sum   = xe_b + EW'(BIAS);
   assign exp_field = mant[FRAC_W] ? exp_sum[EXPF_W-1:0] : '0;
   assign unused_bits = ^{sig_pre[3:0], sig_b[2:0], exp_sum[EW-1:EXPF_W]};

   sp_special_sel #(.EXPF_W(EXPF_W), .FRAC_W(FRAC_W)) u_special (
      .sign       (in_sign),
      .mode       (rnd_mode),
      .flush_word (flush_word),
      .ovf_word   (ovf_word)
   );

   always_comb begin
      if (flush_hit) begin
         res_c = flush_word;
         nx_c  = 1'b1;
         uf_c  = 1'b1;
      end else if (ovf) begin
         res_c = ovf_word;
         nx_c  = 1'b1;
         uf_c  = 1'b0;
      end else begin
         res_c = {in_sign, exp_field, mant[FRAC_W-1:0]};
         nx_c  = nx_a | grs_a;
         uf_c  = grs_a & ~sig_a[SIG_W-1];
      end
   end

   // ---------------- output stage ----------------
   if (PIPE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid     <= 1'b0;
            out_result    <= '0;
            out_inexact   <= 1'b0;
            out_underflow <= 1'b0;
            out_overflow  <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_result    <= res_c;
               out_inexact   <= nx_c;
               out_underflow <= uf_c;
               out_overflow  <= ovf;
            end
         end
      end
   end else begin : g_comb
      assign out_valid     = in_valid;
      assign out_result    = res_c;
      assign out_inexact   = nx_c;
      assign out_underflow = uf_c;
      assign out_overflow  = ovf;
   end
endmodule

// File: rtl/sp_round_pack_chk.sv
module sp_round_pack_chk #(
   parameter int EXPF_W = 8,
   parameter int FRAC_W = 23,
   parameter bit PIPE   = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   out_valid,
   input logic [EXPF_W+FRAC_W:0] out_result,
   input logic                   out_inexact,
   input logic                   out_underflow,
   input logic                   out_overflow
);
   logic [EXPF_W-1:0] fld;
   logic [FRAC_W-1:0] frc;
   assign fld = out_result[EXPF_W+FRAC_W-1:FRAC_W];
   assign frc = out_result[FRAC_W-1:0];

   if (PIPE) begin : g_pipe_chk
      // R1
      a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
   end

   a_r11_overflow_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_overflow) |-> (out_inexact && !out_underflow));

   a_r11_overflow_field: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_overflow) |-> (&fld[EXPF_W-1:1]));

   a_r11_no_nan: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (&fld)) |-> (frc == '0));

   a_r5_underflow_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_underflow) |-> out_inexact);

   a_r7_underflow_field: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_underflow) |-> (fld[EXPF_W-1:1] == '0));
endmodule

bind sp_round_pack sp_round_pack_chk #(
   .EXPF_W (EXPF_W),
   .FRAC_W (FRAC_W),
   .PIPE   (PIPE)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .in_valid      (in_valid),
   .out_valid     (out_valid),
   .out_result    (out_result),
   .out_inexact   (out_inexact),
   .out_underflow (out_underflow),
   .out_overflow  (out_overflow)
);

// File: tb/sp_round_pack_tb_top.sv
module sp_round_pack_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sign = 1'b0;
   logic [9:0]  in_exp = '0;
   logic [26:0] in_sig = 27'h4000000;
   logic [1:0]  rnd_mode = 2'd0;
   logic        flush_en = 1'b0;

   logic        ov_a, nx_a, uf_a, of_a;
   logic [31:0] res_a;
   logic        ov_b, nx_b, uf_b, of_b;
   logic [31:0] res_b;

   sp_round_pack dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_exp(in_exp), .in_sig(in_sig), .rnd_mode(rnd_mode), .flush_en(flush_en),
      .out_valid(ov_a), .out_result(res_a), .out_inexact(nx_a),
      .out_underflow(uf_a), .out_overflow(of_a)
   );

   sp_round_pack #(.PIPE(1'b0), .STAGED(1'b0)) dut_alt_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_exp(in_exp), .in_sig(in_sig), .rnd_mode(rnd_mode), .flush_en(flush_en),
      .out_valid(ov_b), .out_result(res_b), .out_inexact(nx_b),
      .out_underflow(uf_b), .out_overflow(of_b)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(string tag, string what, logic [35:0] act, logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic longint rnd(bit s, longint xm, bit [1:0] rm);
      if ((xm & 64'd7) == 0) return xm;
      case (rm)
         2'd0:    return xm + 3 + ((xm >> 3) & 1);
         2'd1:    return xm;
         2'd2:    return s ? xm : xm + 8;
         default: return s ? xm + 8 : xm;
      endcase
   endfunction

   // returns {valid=1, overflow, underflow, inexact, result}
   function automatic logic [35:0] model(bit s, int e, logic [26:0] m, bit [1:0] rm, bit fz);
      longint xm = longint'(m);
      int xe = e;
      bit nx = 0, uf = 0, isinf;
      logic [31:0] r;
      if (xe < -126) begin
         if (fz) begin
            case (rm)
               2'd0, 2'd1: r = {s, 31'd0};
               2'd2:       r = s ? 32'h8000_0000 : 32'h0000_0001;
               default:    r = s ? 32'h8000_0001 : 32'h0000_0000;
            endcase
            return {1'b1, 1'b0, 1'b1, 1'b1, r};
         end
         if (xe == -127 && (rnd(s, xm, rm) >> 27) != 0) begin
            nx = 1;
            xm = (rnd(s, xm, rm) >> 1) & ~longint'(7);
         end else begin
            int es = -126 - xe;
            if (es >= 27) xm = 1;
            else xm = (xm >> es) | (((xm & ((64'd1 << es) - 1)) != 0) ? 64'd1 : 64'd0);
         end
         xe = -126;
      end
      if ((xm & 64'd7) != 0) begin
         nx = 1;
         if (((xm >> 26) & 1) == 0) uf = 1;
         xm = rnd(s, xm, rm);
         if ((xm >> 27) != 0) begin xm = xm >> 1; xe++; end
      end
      xm = xm >> 3;
      if (xe > 127) begin
         isinf = (rm == 2'd0) || (rm == 2'd2 && !s) || (rm == 2'd3 && s);
         r = isinf ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
         return {1'b1, 1'b1, 1'b0, 1'b1, r};
      end
      if (((xm >> 23) & 1) == 0) r = {s, 8'd0, xm[22:0]};
      else r = {s, 8'(xe + 127), xm[22:0]};
      return {1'b1, 1'b0, uf, nx, r};
   endfunction

   task automatic apply(string tag, bit s, int e, logic [26:0] m, bit [1:0] rm, bit fz);
      logic [35:0] exp_v;
      exp_v = model(s, e, m, rm, fz);
      @(negedge clk);
      in_valid = 1'b1; in_sign = s; in_exp = 10'(e); in_sig = m;
      rnd_mode = rm; flush_en = fz;
      #3;
      check(tag, "comb copy", {ov_b, of_b, uf_b, nx_b, res_b}, exp_v);
      @(negedge clk);
      check(tag, "registered", {ov_a, of_a, uf_a, nx_a, res_a}, exp_v);
      in_valid = 1'b0;
   endtask

   task automatic apply_exp(string tag, bit s, int e, logic [26:0] m, bit [1:0] rm, bit fz,
                            logic [35:0] exp_v);
      check(tag, "hand value", model(s, e, m, rm, fz), exp_v);
      apply(tag, s, e, m, rm, fz);
   endtask

   initial begin : watchdog
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   localparam logic [26:0] ONE = 27'h4000000;
   localparam logic [26:0] ALL = 27'h7FFFFFF;

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "reset outputs", {ov_a, of_a, uf_a, nx_a, res_a}, 36'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "idle after reset", {35'h0, ov_a}, 36'h0);

      // R2 exact
      apply_exp("R2", 0, 0, ONE, 0, 0, {4'b1000, 32'h3F800000});
      apply_exp("R2", 1, 127, ONE | 27'h8, 1, 0, {4'b1000, 32'hFF000001});
      @(negedge clk);
      check("R1", "out_valid drops after idle", {35'h0, ov_a}, 36'h0);
      // R3 nearest even
      apply_exp("R3", 0, 0, ONE | 27'h4, 0, 0, {4'b1001, 32'h3F800000});
      apply_exp("R3", 0, 0, ONE | 27'hC, 0, 0, {4'b1001, 32'h3F800002});
      apply_exp("R3", 0, 0, ONE | 27'h5, 0, 0, {4'b1001, 32'h3F800001});
      // R4 directed modes
      apply_exp("R4", 0, 0, ONE | 27'hF, 1, 0, {4'b1001, 32'h3F800001});
      apply_exp("R4", 0, 0, ONE | 27'h9, 2, 0, {4'b1001, 32'h3F800002});
      apply_exp("R4", 1, 0, ONE | 27'h9, 2, 0, {4'b1001, 32'hBF800001});
      apply_exp("R4", 1, 0, ONE | 27'h9, 3, 0, {4'b1001, 32'hBF800002});
      apply_exp("R4", 0, 0, ONE | 27'h9, 3, 0, {4'b1001, 32'h3F800001});
      // R6 carry
      apply_exp("R6", 0, 0, ALL, 0, 0, {4'b1001, 32'h40000000});
      // R7 exact denormal and R5 underflow
      apply_exp("R7", 0, -127, ONE, 0, 0, {4'b1000, 32'h00400000});
      apply_exp("R5", 0, -127, ONE | 27'h2, 1, 0, {4'b1011, 32'h00400000});
      // R8 not tiny after rounding
      apply_exp("R8", 0, -127, ALL, 0, 0, {4'b1001, 32'h00800000});
      apply_exp("R8", 1, -127, ALL, 3, 0, {4'b1001, 32'h80800000});
      // R9 saturating shift
      apply_exp("R9", 0, -200, ONE, 2, 0, {4'b1011, 32'h00000001});
      apply_exp("R9", 0, -153, ONE, 0, 0, {4'b1011, 32'h00000000});
      apply_exp("R9", 1, -512, ALL, 3, 0, {4'b1011, 32'h80000001});
      // R10 flush, all modes and signs
      for (int k = 0; k < 8; k++) apply("R10", k[0], -130, ONE | 27'h123, k[2:1], 1);
      apply_exp("R10", 0, -127, ALL, 2, 1, {4'b1011, 32'h00000001});
      // R11 overflow, all modes and signs
      for (int k = 0; k < 8; k++) apply("R11", k[0], 128, ONE, k[2:1], 0);
      apply_exp("R11", 0, 127, ALL, 0, 0, {4'b1101, 32'h7F800000});
      apply_exp("R11", 1, 127, ALL, 1, 0, {4'b1001, 32'hFF7FFFFF});
      apply_exp("R11", 1, 511, ONE, 2, 0, {4'b1101, 32'hFF7FFFFF});
      // R12 denormal rounding into hidden bit
      apply_exp("R12", 0, -127, 27'h7FFFFF1, 2, 0, {4'b1011, 32'h00800000});
      // R13 flush has no effect at or above -126
      apply_exp("R13", 0, -126, ONE, 0, 1, {4'b1000, 32'h00800000});
      apply_exp("R13", 1, 0, ONE | 27'h1, 3, 1, {4'b1001, 32'hBF800001});

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         int e;
         logic [26:0] m;
         bit s, fz;
         bit [1:0] rm;
         case ($urandom_range(0, 4))
            0: e = int'($urandom_range(0, 10)) - 130;
            1: e = int'($urandom_range(0, 33)) - 160;
            2: e = int'($urandom_range(0, 10)) + 120;
            3: e = int'($urandom_range(0, 1023)) - 512;
            default: e = int'($urandom_range(0, 40)) - 20;
         endcase
         m = {1'b1, 26'($urandom)};
         if ($urandom_range(0, 3) == 0) m = m | 27'h7FFFFF0;
         s  = 1'($urandom);
         rm = 2'($urandom);
         fz = ($urandom_range(0, 3) == 0);
         if (e < -126) apply(fz ? "R10" : "R7", s, e, m, rm, fz);
         else if (e > 120) apply("R11", s, e, m, rm, fz);
         else apply("R5", s, e, m, rm, fz);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule